// File: doc/BRIEF.md
# Multi-lane Serial Converter Link Receive Synchronizer

This block sits behind the 8b/10b decoders of a multi-lane JESD204B receiver. Each clock it takes one decoded octet per lane, with a flag that marks control characters and a flag that reports a decode fault (a disparity error or a code not in the table). It holds the shared active-low synchronization request low until every lane has seen a steady run of K28.5 commas. It then releases the request and times the lane alignment interval, which lasts four multiframes. The block checks that each lane opened that interval with a K28.0 start marker.

Once alignment is complete, the block rebuilds one frame per lane from consecutive octets and presents the samples of all lanes together on a valid/data output. A comma or a decode fault on any lane during data transfer pulls the request low again and restarts the bring-up. The multiframe length is set by a configuration input that holds the frame count minus one.

Top module: `jrx_link_sync`

## Requirements
- R1: While reset is high and in the first cycle after it, `sync_n` is low and `out_valid`, `mf_start` and `lane_err` are low.
- R2: A lane raises its bit of `lane_cgs_ok` in the cycle after its fourth consecutive comma. A comma is a control character (`rx_is_ctrl` high) with octet value 0xBC and no decode fault. A fault, or any octet that is not a comma, clears that lane's run to zero.
- R3: `sync_n` goes high exactly one cycle after `lane_cgs_ok` is all ones. It never rises while any lane lacks code-group synchronization.
- R4: After `sync_n` rises, the alignment interval spans 4 × (cfg_frames_m1 + 1) frames of 2 octets each. It counts from the first octet presented while `sync_n` is high. During the interval `out_valid` stays low and `sync_n` stays high.
- R5: During alignment, each lane must receive a K28.0 start marker: a control character with octet value 0x1C. If any lane lacks one, `sync_n` is low in the cycle after the interval ends, and no data is delivered.
- R6: `mf_start` is high exactly in the cycles in which the first octet of a multiframe is presented, during both alignment and data. The frame index wraps from cfg_frames_m1 to 0.
- R7: In data phase, `out_valid` is high for one cycle after the second octet of each frame, once every two cycles. Lane l's sample occupies `out_data[16l+15:16l]`, with the first octet of the frame in the upper byte.
- R8: In data phase, a comma or a decode fault on any lane drives `sync_n` low in the next cycle. The same cycle shows `lane_err` set only for the offending lanes. No further `out_valid` appears until a new bring-up completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_frames_m1 | input | 5 | Frames per multiframe minus one |
| rx_octet | input | 16 | Decoded octet per lane, lane l at bits 8l+7:8l |
| rx_is_ctrl | input | 2 | Per-lane control-character flag |
| rx_dec_err | input | 2 | Per-lane decode fault flag |
| sync_n | output | 1 | Active-low synchronization request to the transmitter |
| out_valid | output | 1 | One frame of samples present on out_data |
| out_data | output | 32 | Samples of all lanes, lane l at bits 16l+15:16l |
| lane_cgs_ok | output | 2 | Per-lane code-group synchronization reached |
| lane_err | output | 2 | Per-lane fault that caused a resynchronization |
| mf_start | output | 1 | First octet of a multiframe is being presented |

## Verification
The bench builds the block with its defaults: two lanes, two octets per frame, a comma threshold of four and an alignment span of four multiframes. It sweeps every multiframe setting from one to eight frames. Each pass varies which lane breaks its comma run, and how: through a decode fault or through a non-comma octet. Each pass also varies the fault that ends data phase. One pass withholds the start marker on a lane. These small sizes keep every alignment window short enough to check `mf_start` and `out_valid` cycle by cycle over the whole interval, and let every frame wrap occur many times.

// File: rtl/jrx_pkg.sv
`timescale 1ns/1ps
package jrx_pkg;

    typedef enum logic [1:0] {
        ST_CGS  = 2'd0,
        ST_ILAS = 2'd1,
        ST_DATA = 2'd2
    } link_st_e;

    typedef struct packed {
        logic [7:0] octet;
        logic       ctrl;
        logic       err;
    } lane_sym_t;

    localparam logic [7:0] CHAR_COMMA = 8'hBC;
    localparam logic [7:0] CHAR_START = 8'h1C;

    function automatic logic is_comma(input lane_sym_t s);
        return s.ctrl && (s.octet == CHAR_COMMA);
    endfunction

    function automatic logic is_start(input lane_sym_t s);
        return s.ctrl && (s.octet == CHAR_START) && !s.err;
    endfunction

endpackage

// File: rtl/jrx_frame_ctr.sv
`timescale 1ns/1ps
module jrx_frame_ctr #(
    parameter int F        = 2,
    parameter int KW       = 5,
    parameter int MF_COUNT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [KW-1:0] cfg_frames_m1,
    output logic          oct_last,
    output logic          mf_first,
    output logic          align_done
);
    localparam int OW = (F > 1) ? $clog2(F) : 1;
    localparam int MW = (MF_COUNT > 1) ? $clog2(MF_COUNT) : 1;

    logic [OW-1:0] oct_cnt;
    logic [KW-1:0] fr_cnt;
    logic [MW-1:0] mf_cnt;
    logic          fr_last;

    assign oct_last   = (oct_cnt == OW'(F - 1));
    assign fr_last    = (fr_cnt == cfg_frames_m1);
    assign mf_first   = run && (oct_cnt == '0) && (fr_cnt == '0);
    assign align_done = run && oct_last && fr_last && (mf_cnt == MW'(MF_COUNT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            oct_cnt <= '0;
            fr_cnt  <= '0;
            mf_cnt  <= '0;
        end else begin
            oct_cnt <= oct_last ? '0 : oct_cnt + 1'b1;
            if (oct_last) begin
                fr_cnt <= fr_last ? '0 : fr_cnt + 1'b1;
                if (fr_last)
                    mf_cnt <= (mf_cnt == MW'(MF_COUNT - 1)) ? '0 : mf_cnt + 1'b1;
            end
        end
    end

    // R6
    fr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (fr_cnt <= cfg_frames_m1));

endmodule

// File: rtl/jrx_lane.sv
`timescale 1ns/1ps
module jrx_lane
    import jrx_pkg::*;
#(
    parameter int F        = 2,
    parameter int CGS_NEED = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  lane_sym_t      sym,
    input  link_st_e       st,
    output logic           cgs_ok,
    output logic           start_seen,
    output logic           fault,
    output logic [F*8-1:0] sample
);
    localparam int CW = $clog2(CGS_NEED + 1);

    logic [CW-1:0] run_cnt;
    logic          good_comma;

    assign good_comma = is_comma(sym) && !sym.err;
    assign cgs_ok     = (run_cnt == CW'(CGS_NEED));
    assign fault      = (st == ST_DATA) && (is_comma(sym) || sym.err);

    always_ff @(posedge clk) begin
        if (rst || st != ST_CGS)
            run_cnt <= '0;
        else if (!good_comma)
            run_cnt <= '0;
        else if (!cgs_ok)
            run_cnt <= run_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || st == ST_CGS)
            start_seen <= 1'b0;
        else if (st == ST_ILAS && is_start(sym))
            start_seen <= 1'b1;
    end

    generate
        if (F > 1) begin : g_acc
            logic [(F-1)*8-1:0] acc;
            always_ff @(posedge clk) begin
                if (rst)
                    acc <= '0;
                else if (F > 2)
                    acc <= {acc[(F-1)*8-9:0], sym.octet};
                else
                    acc <= (F-1)*8'(sym.octet);
            end
            assign sample = {acc, sym.octet};
        end else begin : g_single
            assign sample = sym.octet;
        end
    endgenerate

    // R2
    cgs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cgs_ok) |-> $past(good_comma));

endmodule

// File: rtl/jrx_link_sync.sv
`timescale 1ns/1ps
module jrx_link_sync
    import jrx_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int F        = 2,
    parameter int KW       = 5,
    parameter int CGS_NEED = 4,
    parameter int MF_ALIGN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [KW-1:0]        cfg_frames_m1,
    input  logic [LANES*8-1:0]   rx_octet,
    input  logic [LANES-1:0]     rx_is_ctrl,
    input  logic [LANES-1:0]     rx_dec_err,
    output logic                 sync_n,
    output logic                 out_valid,
    output logic [LANES*F*8-1:0] out_data,
    output logic [LANES-1:0]     lane_cgs_ok,
    output logic [LANES-1:0]     lane_err,
    output logic                 mf_start
);
    localparam int SW = F * 8;

    link_st_e                st, st_nx;
    logic [LANES-1:0]        start_seen;
    logic [LANES-1:0]        fault;
    logic [LANES*SW-1:0]     samples;
    logic                    oct_last;
    logic                    align_done;
    logic                    run;

    assign run    = (st != ST_CGS);
    assign sync_n = run;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            lane_sym_t sym;
            assign sym = '{octet: rx_octet[l*8 +: 8], ctrl: rx_is_ctrl[l], err: rx_dec_err[l]};
            jrx_lane #(.F(F), .CGS_NEED(CGS_NEED)) lane_i (
                .clk        (clk),
                .rst        (rst),
                .sym        (sym),
                .st         (st),
                .cgs_ok     (lane_cgs_ok[l]),
                .start_seen (start_seen[l]),
                .fault      (fault[l]),
                .sample     (samples[l*SW +: SW])
            );
        end
    endgenerate

    jrx_frame_ctr #(.F(F), .KW(KW), .MF_COUNT(MF_ALIGN)) ctr_i (
        .clk           (clk),
        .rst           (rst),
        .run           (run),
        .cfg_frames_m1 (cfg_frames_m1),
        .oct_last      (oct_last),
        .mf_first      (mf_start),
        .align_done    (align_done)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_CGS:  if (&lane_cgs_ok) st_nx = ST_ILAS;
            ST_ILAS: if (align_done)   st_nx = (&start_seen) ? ST_DATA : ST_CGS;
            ST_DATA: if (|fault)       st_nx = ST_CGS;
            default: st_nx = ST_CGS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_CGS;
            out_valid <= 1'b0;
            out_data  <= '0;
            lane_err  <= '0;
        end else begin
            st        <= st_nx;
            lane_err  <= fault;
            out_valid <= (st == ST_DATA) && oct_last && !(|fault);
            if ((st == ST_DATA) && oct_last)
                out_data <= samples;
        end
    end

    // R1
    reset_sync_low_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sync_n && !out_valid && lane_err == '0));

    // R3
    sync_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> $past(&lane_cgs_ok));

    // R4
    valid_after_align_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(st == ST_DATA));

    // R5
    missing_start_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ILAS && align_done && !(&start_seen)) |=> !sync_n);

    // R8
    data_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA && |fault) |=> (!sync_n && !out_valid && lane_err != '0));

endmodule

// File: tb/jrx_link_sync_tb_top.sv
`timescale 1ns/1ps
module jrx_link_sync_tb_top;
    localparam int L = 2;
    localparam int F = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic [4:0]    cfg;
    logic [L*8-1:0] rx_octet;
    logic [L-1:0]  rx_ctrl, rx_err;
    logic          sync_n, out_valid, mf_start;
    logic [L*F*8-1:0] out_data;
    logic [L-1:0]  lane_cgs_ok, lane_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    jrx_link_sync dut_i (
        .clk(clk), .rst(rst), .cfg_frames_m1(cfg),
        .rx_octet(rx_octet), .rx_is_ctrl(rx_ctrl), .rx_dec_err(rx_err),
        .sync_n(sync_n), .out_valid(out_valid), .out_data(out_data),
        .lane_cgs_ok(lane_cgs_ok), .lane_err(lane_err), .mf_start(mf_start)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put(input int l, input logic [7:0] o, input logic c, input logic e);
        rx_octet[l*8 +: 8] = o;
        rx_ctrl[l] = c;
        rx_err[l]  = e;
    endtask

    function automatic logic [15:0] frame_of(input int f, input int l);
        logic [7:0] hi, lo;
        hi = 8'((f * 3 + l * 5 + 1) & 8'h7F);
        lo = 8'((f * 7 + l) ^ 8'hA5);
        return {hi, lo};
    endfunction

    function automatic logic [31:0] exp_out(input int f);
        return {frame_of(f, 1), frame_of(f, 0)};
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg = '0; rx_octet = '0; rx_ctrl = '0; rx_err = '0;
        for (int k1 = 0; k1 < 8; k1++) begin
            int kf;
            int cnt_m [L];
            bit prev_all;
            bit bad;
            int nf;
            kf  = (k1 + 1) * F;
            bad = (k1 == 5);
            rst = 1'b1; cfg = 5'(k1); rx_octet = '0; rx_ctrl = '0; rx_err = '0;
            repeat (3) @(negedge clk);
            rst = 1'b0;
            @(negedge clk);
            // R1 reset state
            chk(!sync_n && !out_valid && !mf_start && lane_err == '0 && lane_cgs_ok == '0,
                "R1", {sync_n, out_valid, mf_start, lane_err, lane_cgs_ok}, 0);
            // code-group synchronization with one broken run
            for (int l = 0; l < L; l++) cnt_m[l] = 0;
            prev_all = 1'b0;
            for (int idx = 0; idx < 40; idx++) begin
                chk(sync_n == prev_all, "R3", sync_n, prev_all);
                if (sync_n) break;
                for (int l = 0; l < L; l++)
                    chk(lane_cgs_ok[l] == (cnt_m[l] >= 4), "R2", lane_cgs_ok[l], cnt_m[l] >= 4);
                prev_all = (cnt_m[0] >= 4) && (cnt_m[1] >= 4);
                for (int l = 0; l < L; l++) begin
                    if (l == k1 % 2 && idx == 2 + k1 % 3) begin
                        if (k1 % 2 == 0) put(l, 8'hBC, 1'b1, 1'b1);
                        else             put(l, 8'hBC, 1'b0, 1'b0);
                        cnt_m[l] = 0;
                    end else begin
                        put(l, 8'hBC, 1'b1, 1'b0);
                        cnt_m[l] = (cnt_m[l] < 4) ? cnt_m[l] + 1 : 4;
                    end
                end
                @(negedge clk);
            end
            chk(sync_n == 1'b1, "R3", sync_n, 1);
            // alignment interval
            for (int j = 0; j < 4 * kf; j++) begin
                chk(!out_valid && sync_n, "R4", {out_valid, sync_n}, 1);
                chk(mf_start == (j % kf == 0), "R6", mf_start, j % kf == 0);
                for (int l = 0; l < L; l++) begin
                    if (j == 0 && !(bad && l == 1)) put(l, 8'h1C, 1'b1, 1'b0);
                    else                            put(l, 8'((j * 13 + l) & 8'h7F), 1'b0, 1'b0);
                end
                @(negedge clk);
            end
            if (bad) begin
                // R5 missing start marker on lane 1
                chk(!sync_n && !out_valid, "R5", {sync_n, out_valid}, 0);
                rx_octet = '0; rx_ctrl = '0; rx_err = '0;
                @(negedge clk);
                chk(!sync_n && !out_valid, "R5", {sync_n, out_valid}, 0);
                continue;
            end
            // data phase
            nf = 2 * (k1 + 1) + 2;
            for (int d = 0; d <= 2 * nf; d++) begin
                bit ev;
                ev = (d >= 2) && (d % 2 == 0);
                chk(out_valid == ev, "R7", out_valid, ev);
                if (ev)
                    chk(out_data == exp_out((d - 2) / 2), "R7", out_data, exp_out((d - 2) / 2));
                chk(mf_start == (d % kf == 0), "R6", mf_start, d % kf == 0);
                chk(sync_n == 1'b1, "R7", sync_n, 1);
                if (d == 2 * nf) begin
                    for (int l = 0; l < L; l++) begin
                        if (l == k1 % 2) begin
                            if (k1 % 2 == 0) put(l, 8'h33, 1'b0, 1'b1);
                            else             put(l, 8'hBC, 1'b1, 1'b0);
                        end else begin
                            put(l, frame_of(d / 2, l)[15:8], 1'b0, 1'b0);
                        end
                    end
                end else begin
                    for (int l = 0; l < L; l++) begin
                        logic [15:0] fw;
                        fw = frame_of(d / 2, l);
                        put(l, (d % 2 == 0) ? fw[15:8] : fw[7:0], 1'b0, 1'b0);
                    end
                end
                @(negedge clk);
            end
            // R8 fault during data
            chk(!sync_n, "R8", sync_n, 0);
            chk(lane_err == 2'(1 << (k1 % 2)), "R8", lane_err, 1 << (k1 % 2));
            chk(!out_valid, "R8", out_valid, 0);
            rx_octet = '0; rx_ctrl = '0; rx_err = '0;
            @(negedge clk);
            chk(!sync_n && !out_valid && lane_err == '0, "R8", {sync_n, out_valid, lane_err}, 0);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule